// File: doc/BRIEF.md
# Mask Register Logic Unit

This block combines two 128-bit mask operands with one of eight bitwise logic functions. It merges the result into the current destination mask value under control of a start index and an active length. Bit positions below the start index keep their old destination value. Positions from the start index up to, but not including, the active length take the logic result. Positions at and above the active length are the tail: they become all ones under the agnostic policy, or keep their old value under the undisturbed policy.

When the start index is at or above the active length, the operation writes nothing, not even the tail. Every accepted operation, whether it writes or not, raises a strobe that tells the surrounding pipeline to reset its start index to zero. The result appears one clock after the input is accepted.

A two-state machine sequences each operation. In `ST_IDLE` no result is presented. An accepted input (`in_valid` high) moves the block to `ST_EMIT`, which presents the registered result for one cycle. From `ST_EMIT`, another valid input keeps the block in `ST_EMIT` (back-to-back operation). Without a new input the block returns to `ST_IDLE`. Reset forces `ST_IDLE`.

Top module: `mask_logic_unit`

## Requirements
- R1: `op_sel` selects the function of source A (`src_a`) and source B (`src_b`) as follows: 0 AND, 1 OR, 2 XOR, 3 A AND NOT B, 4 A OR NOT B, 5 NAND, 6 NOR, 7 XNOR.
- R2: When the saturated start index is greater than or equal to the saturated active length, `wr_en` is 0 and `dst_new` equals the old destination value.
- R3: When the start index is nonzero and below the active length, every result bit below the start index equals the old destination bit.
- R4: When the start index is 0 and the active length is nonzero, every bit below the active length equals the logic result.
- R5: With `tail_agnostic` = 1 and a write taking place, every bit at or above the active length is 1.
- R6: With `tail_agnostic` = 0 and a write taking place, every bit at or above the active length equals the old destination bit.
- R7: Start index and active length values above 128 act as 128.
- R8: One cycle after `in_valid` is high, `out_valid` and `vstart_clr` are both 1, whether or not a write happens. Without `in_valid` in the previous cycle, both are 0.
- R9: Valid inputs on consecutive cycles produce a correct result on each of the following cycles.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Active-low asynchronous reset |
| in_valid | input | 1 | Operation accepted this cycle |
| op_sel | input | 3 | Logic function code |
| tail_agnostic | input | 1 | 1: fill the tail with ones, 0: keep the old tail |
| vstart | input | 8 | Start index |
| vl | input | 8 | Active length |
| src_a | input | 128 | First mask operand |
| src_b | input | 128 | Second mask operand |
| dst_old | input | 128 | Current destination mask |
| out_valid | output | 1 | Result presented this cycle |
| dst_new | output | 128 | New destination mask |
| wr_en | output | 1 | Destination must be written |
| vstart_clr | output | 1 | Start index must be reset to zero |

## Verification
The assertions assume that `vstart` and `vl` are free of unknown bits whenever `in_valid` is high. They also assume that `dst_old` holds the destination value at the moment the input is accepted. The stimulus drives every input at the falling edge, to defined values only, before `in_valid` is raised. The stimulus holds the data inputs at zero while the block is idle. It covers start and length values on both sides of 128, so the saturation path is exercised without undefined comparisons.

// File: rtl/mlu_pkg.sv
package mlu_pkg;
    localparam int unsigned MASK_W = 128;
    localparam int unsigned CNT_W  = 8;

    typedef enum logic [2:0] {
        OP_AND  = 3'd0,
        OP_OR   = 3'd1,
        OP_XOR  = 3'd2,
        OP_ANDN = 3'd3,
        OP_ORN  = 3'd4,
        OP_NAND = 3'd5,
        OP_NOR  = 3'd6,
        OP_XNOR = 3'd7
    } logic_op_e;

    typedef enum logic {
        ST_IDLE = 1'b0,
        ST_EMIT = 1'b1
    } mlu_state_e;
endpackage

// File: rtl/mlu_prefix_mask.sv
module mlu_prefix_mask #(
    parameter int unsigned WIDTH = 128,
    parameter int unsigned CW    = 8
) (
    input  logic [CW-1:0]    cnt_i,
    output logic [CW-1:0]    cnt_sat_o,
    output logic [WIDTH-1:0] mask_o
);
    localparam logic [CW-1:0] LIMIT = CW'(WIDTH);

    assign cnt_sat_o = (cnt_i > LIMIT) ? LIMIT : cnt_i;

    for (genvar g = 0; g < WIDTH; g++) begin : g_bit
        assign mask_o[g] = (CW'(g) < cnt_sat_o);
    end

    // The number of set bits must equal the saturated count (R7).
    always_comb begin
        if (!$isunknown(cnt_i)) begin
            assert_prefix_pop_R7: assert ($countones(mask_o) == int'(cnt_sat_o))
                else $error("prefix mask population mismatch");
        end
    end
endmodule

// File: rtl/mlu_logic.sv
module mlu_logic #(
    parameter int unsigned WIDTH = 128
) (
    input  mlu_pkg::logic_op_e op_i,
    input  logic [WIDTH-1:0]   a_i,
    input  logic [WIDTH-1:0]   b_i,
    output logic [WIDTH-1:0]   y_o
);
    import mlu_pkg::*;

    always_comb begin
        unique case (op_i)
            OP_AND:  y_o = a_i & b_i;
            OP_OR:   y_o = a_i | b_i;
            OP_XOR:  y_o = a_i ^ b_i;
            OP_ANDN: y_o = a_i & ~b_i;
            OP_ORN:  y_o = a_i | ~b_i;
            OP_NAND: y_o = ~(a_i & b_i);
            OP_NOR:  y_o = ~(a_i | b_i);
            OP_XNOR: y_o = ~(a_i ^ b_i);
            default: y_o = '0;
        endcase
    end
endmodule

// File: rtl/mask_logic_unit.sv
module mask_logic_unit #(
    parameter int unsigned MASK_W = mlu_pkg::MASK_W,
    parameter int unsigned CNT_W  = mlu_pkg::CNT_W
) (
    input  logic              clk,
    input  logic              rst_n,
    input  logic              in_valid,
    input  logic [2:0]        op_sel,
    input  logic              tail_agnostic,
    input  logic [CNT_W-1:0]  vstart,
    input  logic [CNT_W-1:0]  vl,
    input  logic [MASK_W-1:0] src_a,
    input  logic [MASK_W-1:0] src_b,
    input  logic [MASK_W-1:0] dst_old,
    output logic              out_valid,
    output logic [MASK_W-1:0] dst_new,
    output logic              wr_en,
    output logic              vstart_clr
);
    import mlu_pkg::*;

    localparam logic [MASK_W-1:0] ALL_ONES = '1;

    mlu_state_e        state_q, state_d;
    logic [CNT_W-1:0]  vstart_s, vl_s;
    logic [MASK_W-1:0] start_m, len_m, body_m, tail_m;
    logic [MASK_W-1:0] logic_y, tail_fill, merged;
    logic              do_write;
    logic [MASK_W-1:0] dst_q;
    logic              wr_q;

    mlu_prefix_mask #(.WIDTH(MASK_W), .CW(CNT_W)) u_start_mask (
        .cnt_i(vstart), .cnt_sat_o(vstart_s), .mask_o(start_m)
    );

    mlu_prefix_mask #(.WIDTH(MASK_W), .CW(CNT_W)) u_len_mask (
        .cnt_i(vl), .cnt_sat_o(vl_s), .mask_o(len_m)
    );

    mlu_logic #(.WIDTH(MASK_W)) u_logic (
        .op_i(logic_op_e'(op_sel)), .a_i(src_a), .b_i(src_b), .y_o(logic_y)
    );

    // Merge: prefix keeps old, body takes result, tail follows policy.
    always_comb begin
        do_write  = (vstart_s < vl_s);
        body_m    = len_m & ~start_m;
        tail_m    = ~len_m;
        tail_fill = tail_agnostic ? ALL_ONES : dst_old;
        if (do_write) begin
            merged = (dst_old & start_m) | (logic_y & body_m) | (tail_fill & tail_m);
        end else begin
            merged = dst_old;
        end
    end

    // Next-state decision.
    always_comb begin
        state_d = state_q;
        unique case (state_q)
            ST_IDLE: state_d = in_valid ? ST_EMIT : ST_IDLE;
            ST_EMIT: state_d = in_valid ? ST_EMIT : ST_IDLE;
            default: state_d = ST_IDLE;
        endcase
    end

    // State register.
    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) begin
            state_q <= ST_IDLE;
        end else begin
            state_q <= state_d;
        end
    end

    // Output registers: captured on every accepted operation.
    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) begin
            dst_q <= '0;
            wr_q  <= 1'b0;
        end else if (in_valid) begin
            dst_q <= merged;
            wr_q  <= do_write;
        end else begin
            wr_q  <= 1'b0;
        end
    end

    assign dst_new    = dst_q;
    assign wr_en      = wr_q;
    assign out_valid  = (state_q == ST_EMIT);
    assign vstart_clr = (state_q == ST_EMIT);

    assert_valid_latency_R8: assert property (@(posedge clk) disable iff (!rst_n)
        in_valid |=> (out_valid && vstart_clr))
        else $error("missing result or clear strobe after valid");

    assert_idle_quiet_R8: assert property (@(posedge clk) disable iff (!rst_n)
        !in_valid |=> (!out_valid && !vstart_clr && !wr_en))
        else $error("output activity without valid");

    assert_no_write_R2: assert property (@(posedge clk) disable iff (!rst_n)
        (in_valid && (vstart_s >= vl_s)) |=> (!wr_en && dst_new == $past(dst_old)))
        else $error("write despite empty body");

    assert_prefix_kept_R3: assert property (@(posedge clk) disable iff (!rst_n)
        (in_valid && (vstart_s < vl_s)) |=>
            (((dst_new ^ $past(dst_old)) & $past(start_m)) == '0))
        else $error("prefix bits disturbed");

    assert_tail_ones_R5: assert property (@(posedge clk) disable iff (!rst_n)
        (in_valid && tail_agnostic && (vstart_s < vl_s)) |=>
            ((dst_new | $past(len_m)) == ALL_ONES))
        else $error("agnostic tail not all ones");

    assert_tail_kept_R6: assert property (@(posedge clk) disable iff (!rst_n)
        (in_valid && !tail_agnostic && (vstart_s < vl_s)) |=>
            (((dst_new ^ $past(dst_old)) & ~$past(len_m)) == '0))
        else $error("undisturbed tail changed");
endmodule

// File: tb/mask_logic_unit_tb_top.sv
module mask_logic_unit_tb_top;
    localparam int CLK_PERIOD = 10;

    logic         clk = 1'b0;
    logic         rst_n = 1'b0;
    logic         in_valid = 1'b0;
    logic [2:0]   op_sel = '0;
    logic         tail_agnostic = 1'b0;
    logic [7:0]   vstart = '0;
    logic [7:0]   vl = '0;
    logic [127:0] src_a = '0;
    logic [127:0] src_b = '0;
    logic [127:0] dst_old = '0;
    logic         out_valid;
    logic [127:0] dst_new;
    logic         wr_en;
    logic         vstart_clr;

    int checks = 0;
    int errors = 0;
    bit done = 1'b0;

    localparam logic [127:0] PA = 128'hF0F0_1234_AAAA_5555_0F0F_FFFF_0000_C3C3;
    localparam logic [127:0] PB = 128'hFF00_ABCD_5A5A_0F0F_3333_0000_FFFF_9999;
    localparam logic [127:0] PO = 128'h1111_2222_3333_4444_5555_6666_7777_8888;

    always #(CLK_PERIOD/2) clk = ~clk;

    mask_logic_unit dut_i (
        .clk(clk), .rst_n(rst_n), .in_valid(in_valid), .op_sel(op_sel),
        .tail_agnostic(tail_agnostic), .vstart(vstart), .vl(vl),
        .src_a(src_a), .src_b(src_b), .dst_old(dst_old),
        .out_valid(out_valid), .dst_new(dst_new), .wr_en(wr_en),
        .vstart_clr(vstart_clr)
    );

    function automatic bit fn_bit(input logic [2:0] op, input bit a, input bit b);
        case (op)
            3'd0: return a & b;
            3'd1: return a | b;
            3'd2: return a ^ b;
            3'd3: return a & !b;
            3'd4: return a | !b;
            3'd5: return !(a & b);
            3'd6: return !(a | b);
            default: return !(a ^ b);
        endcase
    endfunction

    function automatic int sat(input logic [7:0] v);
        return (int'(v) > 128) ? 128 : int'(v);
    endfunction

    function automatic logic [127:0] exp_dst(input logic [2:0] op, input bit agn,
        input logic [7:0] vs, input logic [7:0] len,
        input logic [127:0] a, input logic [127:0] b, input logic [127:0] old);
        logic [127:0] r;
        int s;
        int l;
        s = sat(vs);
        l = sat(len);
        r = old;
        if (s < l) begin
            for (int i = 0; i < 128; i++) begin
                if (i < s)      r[i] = old[i];
                else if (i < l) r[i] = fn_bit(op, a[i], b[i]);
                else            r[i] = agn ? 1'b1 : old[i];
            end
        end
        return r;
    endfunction

    task automatic check(input bit ok, input string req, input logic [127:0] act,
                         input logic [127:0] expv);
        checks++;
        if (!ok) begin
            errors++;
            $display("FAIL %s actual=%h expected=%h", req, act, expv);
        end
    endtask

    task automatic drive(input logic [2:0] op, input bit agn, input logic [7:0] vs,
        input logic [7:0] len, input logic [127:0] a, input logic [127:0] b,
        input logic [127:0] old);
        in_valid = 1'b1; op_sel = op; tail_agnostic = agn; vstart = vs; vl = len;
        src_a = a; src_b = b; dst_old = old;
    endtask

    task automatic idle_inputs();
        in_valid = 1'b0; op_sel = '0; tail_agnostic = 1'b0; vstart = '0; vl = '0;
        src_a = '0; src_b = '0; dst_old = '0;
    endtask

    task automatic run_one(input string req, input logic [2:0] op, input bit agn,
        input logic [7:0] vs, input logic [7:0] len, input logic [127:0] a,
        input logic [127:0] b, input logic [127:0] old);
        logic [127:0] e;
        bit ew;
        e  = exp_dst(op, agn, vs, len, a, b, old);
        ew = sat(vs) < sat(len);
        drive(op, agn, vs, len, a, b, old);
        @(negedge clk);
        idle_inputs();
        check(out_valid && vstart_clr, {req, " R8 strobes"}, {126'd0, out_valid, vstart_clr}, 128'd3);
        check(wr_en == ew, {req, " wr_en"}, {127'd0, wr_en}, {127'd0, ew});
        check(dst_new == e, {req, " dst_new"}, dst_new, e);
    endtask

    task automatic t_reset();
        check(!out_valid && !wr_en && !vstart_clr && dst_new == '0, "reset R8",
              {125'd0, out_valid, wr_en, vstart_clr}, 128'd0);
    endtask

    task automatic t_all_ops();
        for (int k = 0; k < 8; k++) begin
            run_one("R1 R4 op", 3'(k), 1'b1, 8'd0, 8'd128, PA, PB, PO);
            @(negedge clk);
        end
    endtask

    task automatic t_prefix();
        run_one("R3 prefix", 3'd2, 1'b0, 8'd37, 8'd100, PA, PB, PO);
        @(negedge clk);
        run_one("R3 prefix one", 3'd6, 1'b1, 8'd1, 8'd2, PA, PB, PO);
        @(negedge clk);
    endtask

    task automatic t_empty();
        run_one("R2 equal", 3'd1, 1'b1, 8'd50, 8'd50, PA, PB, PO);
        @(negedge clk);
        run_one("R2 above", 3'd1, 1'b1, 8'd90, 8'd10, PA, PB, PO);
        @(negedge clk);
        run_one("R2 zero len", 3'd0, 1'b1, 8'd0, 8'd0, PA, PB, PO);
        @(negedge clk);
    endtask

    task automatic t_tail();
        run_one("R5 agnostic", 3'd0, 1'b1, 8'd0, 8'd64, PA, PB, PO);
        @(negedge clk);
        run_one("R6 undisturbed", 3'd0, 1'b0, 8'd0, 8'd64, PA, PB, PO);
        @(negedge clk);
        run_one("R6 undisturbed short", 3'd4, 1'b0, 8'd3, 8'd7, PA, PB, PO);
        @(negedge clk);
    endtask

    task automatic t_saturate();
        run_one("R7 long len", 3'd2, 1'b1, 8'd0, 8'd200, PA, PB, PO);
        @(negedge clk);
        run_one("R7 both over", 3'd2, 1'b1, 8'd129, 8'd255, PA, PB, PO);
        @(negedge clk);
        run_one("R7 start 127", 3'd7, 1'b0, 8'd127, 8'd250, PA, PB, PO);
        @(negedge clk);
    endtask

    task automatic t_idle();
        @(negedge clk);
        check(!out_valid && !vstart_clr && !wr_en, "R8 idle quiet",
              {125'd0, out_valid, vstart_clr, wr_en}, 128'd0);
    endtask

    task automatic t_back_to_back();
        logic [127:0] e1;
        logic [127:0] e2;
        e1 = exp_dst(3'd3, 1'b1, 8'd5, 8'd90, PA, PB, PO);
        e2 = exp_dst(3'd5, 1'b0, 8'd0, 8'd40, PB, PA, ~PO);
        drive(3'd3, 1'b1, 8'd5, 8'd90, PA, PB, PO);
        @(negedge clk);
        drive(3'd5, 1'b0, 8'd0, 8'd40, PB, PA, ~PO);
        check(out_valid && dst_new == e1, "R9 first", dst_new, e1);
        @(negedge clk);
        idle_inputs();
        check(out_valid && vstart_clr && dst_new == e2, "R9 second", dst_new, e2);
        @(negedge clk);
    endtask

    initial begin
        #(CLK_PERIOD * 100000);
        if (!done) begin
            errors++;
            $display("FAIL watchdog actual=%0d expected=%0d", 0, 1);
            $display("CHECKS %0d ERRORS %0d", checks, errors);
            $finish;
        end
    end

    initial begin
        repeat (3) @(negedge clk);
        t_reset();
        rst_n = 1'b1;
        @(negedge clk);
        t_all_ops();
        t_prefix();
        t_empty();
        t_tail();
        t_saturate();
        t_idle();
        t_back_to_back();
        done = 1'b1;
        $display("CHECKS %0d ERRORS %0d", checks, errors);
        $finish;
    end
endmodule